// File: doc/BRIEF.md
# Remote DMA Bus Bridge Controller

This block sits between a byte-wide bus interface chip and a pair of local byte buffers while remote DMA is running. It steers the address and read/write lines of the interface chip. During a remote transfer the address is pinned to the chip's data FIFO register. At all other times the DMA bus drives the address and read/write lines.

Each remote byte moves under a synchronous I/O strobe. The strobe is active low and lasts a programmable number of clock cycles. When the buffers supply the data, the strobe waits for a delayed-read timing pulse, so the data is already stable on the bus before the strobe asserts. When the interface chip supplies the data, the strobe starts at once. At the end of such a byte the strobe also captures two tag bits that arrive with the byte.

A tag that marks end-or-identify or a secondary address sets a sticky stop latch. The stop latch masks the remote grant and blocks new transfers. The only way to clear it is for the processor to drive its direction bit low. The even/odd bit of the DMA address picks one of the two buffer banks.

Top module: `rdma_bridge`

## Requirements
- R1: While `remEnN` is 0, `chipAddr` equals the FIFO register address (default 2). While `remEnN` is 1, `chipAddr` equals `dmaAddr`.
- R2: While `remEnN` is 0, `chipRw` equals `dirIn`. While `remEnN` is 1, `chipRw` equals `dmaRw`. Here 1 means the chip is read (chip to buffers) and 0 means buffers to chip.
- R3: With `dirIn`=1, a `cycleStart` sampled at one clock edge (remote enabled, stop clear, block idle) drives `ioGoN` low from that edge onward, for exactly `strobeLen` cycles.
- R4: With `dirIn`=0, `ioGoN` stays high after the start until `delayRd` is sampled high. From that edge onward it is low for exactly `strobeLen` cycles.
- R5: A `strobeLen` of 0 gives a one-cycle strobe.
- R6: `tagQ` takes the value of `tagIn` at the edge that ends the strobe of a `dirIn`=1 transfer. A `dirIn`=0 transfer leaves `tagQ` unchanged.
- R7: If `tagIn[1]` (the end-or-identify / secondary-address marker) is 1 at the end of a `dirIn`=1 transfer, `stopStat` becomes 1 at that edge.
- R8: `stopStat` clears at a clock edge where `dirIn` is sampled 0. While `dirIn` stays 1, `stopStat` does not change once it is set.
- R9: While `stopStat` is 1, `remGrantOk` is 0 and `cycleStart` starts no strobe. While `stopStat` is 0, `remGrantOk` equals `dmaReq`.
- R10: `bankSel` is one-hot. An even `dmaAddr` (bit 0 = 0) gives 2'b01 (bank 0) and an odd address gives 2'b10 (bank 1).
- R11: After reset, `ioGoN` is 1, `tagQ` is 0 and `stopStat` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| remEnN | input | 1 | Remote transfer enable, active low |
| dirIn | input | 1 | Processor direction bit: 1 chip to buffers, 0 buffers to chip |
| cycleStart | input | 1 | Request to move one remote byte |
| delayRd | input | 1 | Delayed-read timing pulse for buffer-to-chip bytes |
| strobeLen | input | LEN_W | Strobe length in cycles (0 acts as 1) |
| dmaAddr | input | CHIP_ADDR_W | DMA bus address lines |
| dmaRw | input | 1 | DMA controller read/write line |
| dmaReq | input | 1 | Remote DMA request |
| tagIn | input | 2 | Tag bits of the inbound byte; bit 1 marks end/secondary |
| chipAddr | output | CHIP_ADDR_W | Address to the interface chip |
| chipRw | output | 1 | Read/write to the interface chip |
| ioGoN | output | 1 | I/O strobe, active low |
| tagQ | output | 2 | Latched tag bits |
| stopStat | output | 1 | Stop latch status |
| remGrantOk | output | 1 | Request gated by the stop latch |
| bankSel | output | NUM_BANKS | One-hot buffer bank select |

## Verification
The hardest situation to set up is a start request that arrives while the stop latch is set. Only a chip-to-buffers byte that carries the end marker reaches that state, and any cycle in which the direction bit is low silently clears it again. The stimulus therefore chains random transfers, each with its own direction, tag, length and delayed-read wait. It tracks the expected latch state across transfers, so a blocked start comes up whenever a marked inbound byte is followed by another inbound request. Directed sequences cover the set, block and clear steps in order, as well as a zero-length strobe.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_PULSE = 2'd2
  } ctrlState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic captureTag;  // last strobe cycle of a chip-to-buffer byte
    logic clearStop;   // direction bit low
  } dpStrobe_t;

  localparam int TAG_W   = 2;
  localparam int STOP_TAG = 1;  // tag bit that marks end/secondary
endpackage

// File: rtl/rdma_ctrl.sv
module rdma_ctrl
  import rdma_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             remEnN,
  input  logic             dirIn,
  input  logic             cycleStart,
  input  logic             delayRd,
  input  logic [LEN_W-1:0] strobeLen,
  input  logic             stopQ,
  output logic             ioGoN,
  output dpStrobe_t        dpStrobe
);
  ctrlState_e      state;
  logic [LEN_W-1:0] cnt;
  logic            xferDir;
  logic [LEN_W-1:0] lenEff;
  logic            startOk;
  logic            lastBeat;

  assign lenEff   = (strobeLen == '0) ? LEN_W'(1) : strobeLen;
  assign startOk  = cycleStart && !remEnN && !stopQ && (state == ST_IDLE);
  assign lastBeat = (state == ST_PULSE) && (cnt == LEN_W'(1)) && !remEnN;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      xferDir <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (startOk) begin
            xferDir <= dirIn;
            cnt     <= lenEff;
            state   <= dirIn ? ST_PULSE : ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (remEnN)       state <= ST_IDLE;
          else if (delayRd) state <= ST_PULSE;
        end
        ST_PULSE: begin
          if (remEnN || cnt == LEN_W'(1)) state <= ST_IDLE;
          else cnt <= cnt - LEN_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign ioGoN               = (state != ST_PULSE);
  assign dpStrobe.captureTag = lastBeat && xferDir;
  assign dpStrobe.clearStop  = !dirIn;
endmodule

// File: rtl/rdma_datapath.sv
module rdma_datapath
  import rdma_pkg::*;
#(
  parameter int CHIP_ADDR_W = 3,
  parameter int FIFO_ADDR   = 2,
  parameter int NUM_BANKS   = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   remEnN,
  input  logic                   dirIn,
  input  logic [CHIP_ADDR_W-1:0] dmaAddr,
  input  logic                   dmaRw,
  input  logic                   dmaReq,
  input  logic [TAG_W-1:0]       tagIn,
  input  dpStrobe_t              dpStrobe,
  output logic [CHIP_ADDR_W-1:0] chipAddr,
  output logic                   chipRw,
  output logic [TAG_W-1:0]       tagQ,
  output logic                   stopQ,
  output logic                   remGrantOk,
  output logic [NUM_BANKS-1:0]   bankSel
);
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tagQ  <= '0;
      stopQ <= 1'b0;
    end else begin
      if (dpStrobe.captureTag) tagQ <= tagIn;
      if (dpStrobe.clearStop) stopQ <= 1'b0;
      else if (dpStrobe.captureTag && tagIn[STOP_TAG]) stopQ <= 1'b1;
    end
  end

  assign chipAddr   = remEnN ? dmaAddr : CHIP_ADDR_W'(FIFO_ADDR);
  assign chipRw     = remEnN ? dmaRw : dirIn;
  assign remGrantOk = dmaReq && !stopQ;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bankSel[b] = (dmaAddr[BANK_W-1:0] == BANK_W'(b));
  end
endmodule

// File: rtl/rdma_bridge.sv
module rdma_bridge
  import rdma_pkg::*;
#(
  parameter int CHIP_ADDR_W = 3,
  parameter int FIFO_ADDR   = 2,
  parameter int NUM_BANKS   = 2,
  parameter int LEN_W       = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   remEnN,
  input  logic                   dirIn,
  input  logic                   cycleStart,
  input  logic                   delayRd,
  input  logic [LEN_W-1:0]       strobeLen,
  input  logic [CHIP_ADDR_W-1:0] dmaAddr,
  input  logic                   dmaRw,
  input  logic                   dmaReq,
  input  logic [1:0]             tagIn,
  output logic [CHIP_ADDR_W-1:0] chipAddr,
  output logic                   chipRw,
  output logic                   ioGoN,
  output logic [1:0]             tagQ,
  output logic                   stopStat,
  output logic                   remGrantOk,
  output logic [NUM_BANKS-1:0]   bankSel
);
  dpStrobe_t dpStrobe;

  rdma_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .remEnN(remEnN), .dirIn(dirIn),
    .cycleStart(cycleStart), .delayRd(delayRd), .strobeLen(strobeLen),
    .stopQ(stopStat), .ioGoN(ioGoN), .dpStrobe(dpStrobe)
  );

  rdma_datapath #(
    .CHIP_ADDR_W(CHIP_ADDR_W), .FIFO_ADDR(FIFO_ADDR), .NUM_BANKS(NUM_BANKS)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .remEnN(remEnN), .dirIn(dirIn),
    .dmaAddr(dmaAddr), .dmaRw(dmaRw), .dmaReq(dmaReq), .tagIn(tagIn),
    .dpStrobe(dpStrobe), .chipAddr(chipAddr), .chipRw(chipRw),
    .tagQ(tagQ), .stopQ(stopStat), .remGrantOk(remGrantOk), .bankSel(bankSel)
  );
endmodule

// File: rtl/rdma_bridge_chk.sv
module rdma_bridge_chk #(
  parameter int CHIP_ADDR_W = 3,
  parameter int FIFO_ADDR   = 2,
  parameter int NUM_BANKS   = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   remEnN,
  input logic                   dirIn,
  input logic                   delayRd,
  input logic                   dmaReq,
  input logic [1:0]             tagIn,
  input logic [CHIP_ADDR_W-1:0] chipAddr,
  input logic                   chipRw,
  input logic                   ioGoN,
  input logic [1:0]             tagQ,
  input logic                   stopStat,
  input logic                   remGrantOk,
  input logic [NUM_BANKS-1:0]   bankSel
);
  assert_fifo_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !remEnN |-> chipAddr == CHIP_ADDR_W'(FIFO_ADDR));

  assert_delayed_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ioGoN) && !chipRw && !remEnN) |-> $past(delayRd));

  assert_tag_on_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tagQ) |-> ($past(!ioGoN) && $past(dirIn)));

  assert_stop_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stopStat) |-> ($past(tagIn[1]) && $past(!ioGoN)));

  assert_stop_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stopStat && dirIn) |=> stopStat);

  assert_grant_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stopStat && dmaReq) |-> !remGrantOk);

  assert_bank_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(bankSel));
endmodule

bind rdma_bridge rdma_bridge_chk #(
  .CHIP_ADDR_W(CHIP_ADDR_W), .FIFO_ADDR(FIFO_ADDR), .NUM_BANKS(NUM_BANKS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .remEnN(remEnN), .dirIn(dirIn), .delayRd(delayRd),
  .dmaReq(dmaReq), .tagIn(tagIn), .chipAddr(chipAddr), .chipRw(chipRw),
  .ioGoN(ioGoN), .tagQ(tagQ), .stopStat(stopStat), .remGrantOk(remGrantOk),
  .bankSel(bankSel)
);

// File: tb/rdma_bridge_tb.sv
module rdma_bridge_tb;
  localparam int AW = 3;
  localparam int LW = 4;
  localparam int FIFO = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic remEnN = 1'b1, dirIn = 1'b1, cycleStart = 1'b0, delayRd = 1'b0;
  logic [LW-1:0] strobeLen = '0;
  logic [AW-1:0] dmaAddr = '0;
  logic dmaRw = 1'b0, dmaReq = 1'b0;
  logic [1:0] tagIn = '0;
  logic [AW-1:0] chipAddr;
  logic chipRw, ioGoN, stopStat, remGrantOk;
  logic [1:0] tagQ, bankSel;

  int checks = 0, fails = 0;
  logic [1:0] expTag = '0;
  logic expStop = 1'b0;
  bit done = 0;

  always #4 clk = ~clk;

  rdma_bridge #(.CHIP_ADDR_W(AW), .FIFO_ADDR(FIFO), .NUM_BANKS(2), .LEN_W(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .remEnN(remEnN), .dirIn(dirIn), .cycleStart(cycleStart),
    .delayRd(delayRd), .strobeLen(strobeLen), .dmaAddr(dmaAddr), .dmaRw(dmaRw),
    .dmaReq(dmaReq), .tagIn(tagIn), .chipAddr(chipAddr), .chipRw(chipRw),
    .ioGoN(ioGoN), .tagQ(tagQ), .stopStat(stopStat), .remGrantOk(remGrantOk),
    .bankSel(bankSel)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expWidth(input int len);
    return (len == 0) ? 1 : len;
  endfunction

  function automatic int expBank(input logic [AW-1:0] a);
    return a[0] ? 2 : 1;
  endfunction

  task automatic runXfer(input logic d, input logic [1:0] tg, input int len, input int dly);
    bit blocked;
    int width;
    @(negedge clk);
    dirIn = d; tagIn = tg; remEnN = 1'b0; strobeLen = LW'(len); dmaReq = 1'b1;
    @(negedge clk);
    if (!d) expStop = 1'b0;
    check("R8 stop after direction set", int'(stopStat), int'(expStop));
    check("R9 grant gating", int'(remGrantOk), int'(!expStop));
    blocked = expStop;
    cycleStart = 1'b1;
    @(negedge clk);
    cycleStart = 1'b0;
    if (!d) begin
      for (int i = 0; i < dly; i++) begin
        check("R4 strobe held for delayRd", int'(ioGoN), 1);
        @(negedge clk);
      end
      delayRd = 1'b1;
      @(negedge clk);
      delayRd = 1'b0;
    end
    width = 0;
    while (ioGoN == 1'b0 && width < 64) begin
      width++;
      @(negedge clk);
    end
    if (blocked) check("R9 start ignored while stopped", width, 0);
    else if (d) check(len == 0 ? "R5 zero length" : "R3 inbound strobe width", width, expWidth(len));
    else check(len == 0 ? "R5 zero length" : "R4 outbound strobe width", width, expWidth(len));
    if (d && !blocked) begin
      expTag = tg;
      if (tg[1]) expStop = 1'b1;
    end
    check("R6 tag latch", int'(tagQ), int'(expTag));
    check("R7 stop latch", int'(stopStat), int'(expStop));
  endtask

  task automatic muxCheck(input logic en, input logic [AW-1:0] a, input logic rw, input logic d);
    @(negedge clk);
    remEnN = en; dmaAddr = a; dmaRw = rw; dirIn = d;
    #1;
    check("R1 chip address", int'(chipAddr), en ? int'(a) : FIFO);
    check("R2 chip read/write", int'(chipRw), en ? int'(rw) : int'(d));
    check("R10 bank select", int'(bankSel), expBank(a));
    if (!d) expStop = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R11 reset strobe", int'(ioGoN), 1);
    check("R11 reset tag", int'(tagQ), 0);
    check("R11 reset stop", int'(stopStat), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 strobe idle after reset", int'(ioGoN), 1);

    // Directed corner cases
    runXfer(1'b1, 2'b01, 3, 0);   // R6 latch, no stop
    runXfer(1'b0, 2'b11, 4, 3);   // R6 unchanged on outbound
    runXfer(1'b1, 2'b00, 0, 0);   // R5
    runXfer(1'b0, 2'b00, 0, 0);   // R5 outbound
    runXfer(1'b1, 2'b10, 2, 0);   // R7 set
    runXfer(1'b1, 2'b01, 2, 0);   // R9 blocked, R8 held
    runXfer(1'b0, 2'b00, 5, 1);   // R8 cleared by direction low
    runXfer(1'b1, 2'b11, 15, 0);  // R3 max length, R7 set
    muxCheck(1'b1, 3'd5, 1'b0, 1'b1);
    muxCheck(1'b0, 3'd4, 1'b1, 1'b0);

    for (int n = 0; n < 300; n++) begin
      if ($urandom_range(0, 3) == 0)
        muxCheck(1'($urandom_range(0, 1)), AW'($urandom_range(0, 7)),
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      else
        runXfer(1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
                $urandom_range(0, 7), $urandom_range(0, 5));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule